// File: doc/BRIEF.md
# I2C Command-Word Master

This block is a single-master I2C controller fed by a queue of data-command words. Each word describes one byte on the bus: either a byte to transmit, or a request to receive one byte, which lands in a receive queue. The engine creates the START, address byte, per-byte acknowledge handling, repeated START and STOP on its own, deciding from the word stream and a hold control when to end a transfer.

Software, or a sequencer, pushes words, selects the 7-bit target and raises `enable`. The bus stays claimed for as long as words keep arriving. When the queue runs dry, the master either closes with STOP or, if `stop_hold` is set, parks with SCL low until more words arrive or the hold is dropped. Bit pacing comes from an external strobe `tick`, one per quarter of an SCL period, produced by a separate timing block.

Top module: `i2c_cmd_master`

## Requirements
- R1: A command word is 10 bits. Bits 7:0 carry the byte to send. Bit 8 = 1 requests one received byte, and its bits 7:0 are then ignored. Transmitted bytes go out MSB first, after an address byte made of the 7-bit target followed by the R/W bit (0 = write, 1 = read).
- R2: Each read word stores exactly one received byte in the receive queue, oldest first. The master acknowledges a received byte only when the next queued word is a read without a stop request. Otherwise it answers NACK.
- R3: Bit 9 = 1 in a word issues STOP right after that byte, even when more words are queued. A later word then begins with a fresh START.
- R4: When the transmit queue empties with `stop_hold` = 0, STOP follows the last byte. With `stop_hold` = 1, SCL is held low and master-active stays 1. Words pushed meanwhile continue the transfer without a new START, and clearing `stop_hold` issues STOP.
- R5: A change of direction, or a read that follows a NACKed read, is preceded by a repeated START and a new address byte carrying the new R/W bit, with no STOP in between.
- R6: `addr_load` captures `target_addr` only while the transmit queue is empty and the master is idle. Otherwise the load is ignored.
- R7: `status` bit 6 is slave-active (always 0), bit 5 master-active, bit 4 RX full, bit 3 RX not empty, bit 2 TX empty, bit 1 TX not full, and bit 0 any activity (master active or TX not empty). After reset it reads 7'b0000110.
- R8: A NACK to the address byte sets `abort_src` bit 0, and a NACK to a written byte sets bit 1. Either abort flushes the transmit queue, issues STOP and returns to idle.
- R9: A received byte that finds the receive queue full is dropped and sets the sticky `rx_overflow`. `err_clr` clears `rx_overflow` and `abort_src`.
- R10: A push into a full transmit queue, and a pop from an empty receive queue, are ignored.
- R11: SCL changes only in the cycle after a `tick`. With the master idle, neither line is driven.
- R12: With `enable` = 0, an idle master starts no transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Allows a new transfer to start |
| stop_hold | input | 1 | Keep the bus claimed when the queue empties |
| tick | input | 1 | Quarter-SCL-period strobe from the timing block |
| addr_load | input | 1 | Capture `target_addr` |
| target_addr | input | 7 | 7-bit target address |
| tx_push | input | 1 | Push `tx_word` into the transmit queue |
| tx_word | input | 10 | Command word: {stop, read, byte} |
| rx_pop | input | 1 | Remove the head of the receive queue |
| rx_byte | output | 8 | Head of the receive queue |
| status | output | 7 | Queue and activity status |
| abort_src | output | 2 | Sticky abort cause: bit 0 address NACK, bit 1 data NACK |
| rx_overflow | output | 1 | Sticky receive overflow |
| err_clr | input | 1 | Clears `abort_src` and `rx_overflow` |
| sda_in | input | 1 | Sampled SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |

## Verification
The bench builds the master with a queue depth of 4 instead of 16. With that depth, a full transmit queue, a dropped fifth push and a receive overflow all occur within a handful of bus bytes. It also lets a five-byte read exercise refilling the queue while a transfer is under way. The `tick` strobe fires every second clock, so a whole byte takes well under a hundred cycles, and dozens of random write and read transfers against a modelled target fit in the run.

// File: rtl/i2c_cmd_master.sv
module i2c_cmd_master #(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       stop_hold,
  input  logic       tick,
  input  logic       addr_load,
  input  logic [6:0] target_addr,
  input  logic       tx_push,
  input  logic [9:0] tx_word,
  input  logic       rx_pop,
  output logic [7:0] rx_byte,
  output logic [6:0] status,
  output logic [1:0] abort_src,
  output logic       rx_overflow,
  input  logic       err_clr,
  input  logic       sda_in,
  output logic       scl_oe,
  output logic       sda_oe
);

  typedef enum logic [2:0] {S_IDLE, S_START, S_ADDR, S_WR, S_RD, S_HOLD, S_STOP} st_t;

  logic [9:0] txm [DEPTH];
  logic [7:0] rxm [DEPTH];
  logic [AW-1:0] twp, trp, rwp, rrp;
  logic [CW-1:0] tcnt, rcnt;

  st_t st, adv_st;
  logic [1:0] q;
  logic [3:0] bc;
  logic [7:0] sh;
  logic [6:0] addr_q;
  logic dir, cur_stop, need_rs, nack_got, rd_ack;

  wire [9:0] head     = txm[trp];
  wire tx_empty       = tcnt == '0;
  wire tx_full        = tcnt == CW'(DEPTH);
  wire rx_empty       = rcnt == '0;
  wire rx_full        = rcnt == CW'(DEPTH);
  wire active         = st != S_IDLE;
  wire bit_end        = tick && q == 2'd3;
  wire ack_end        = bit_end && bc == 4'd8;
  wire xmit_st        = st == S_ADDR || st == S_WR;
  wire nack_abort     = ack_end && xmit_st && nack_got;
  wire byte_adv       = ack_end && (xmit_st || st == S_RD) && !nack_abort;
  wire adv_now        = byte_adv || (tick && st == S_HOLD);
  wire rs_req         = need_rs || (st == S_RD && !rd_ack);
  logic adv_pop;
  wire tx_pop         = adv_now && adv_pop;
  wire rx_in          = ack_end && st == S_RD;
  wire push_ok        = tx_push && !tx_full;
  wire pop_ok         = rx_pop && !rx_empty;

  always_comb begin
    adv_st  = S_STOP;
    adv_pop = 1'b0;
    if (cur_stop) adv_st = S_STOP;
    else if (!tx_empty) begin
      if (head[8] != dir || rs_req) adv_st = S_START;
      else begin
        adv_st  = head[8] ? S_RD : S_WR;
        adv_pop = 1'b1;
      end
    end else if (stop_hold) adv_st = S_HOLD;
  end

  assign rx_byte = rxm[rrp];
  assign status  = {1'b0, active, rx_full, !rx_empty, tx_empty, !tx_full, active || !tx_empty};

  always_comb begin
    scl_oe = 1'b0;
    sda_oe = 1'b0;
    case (st)
      S_START: begin scl_oe = q == 2'd0 || q == 2'd3; sda_oe = q[1]; end
      S_ADDR, S_WR: begin scl_oe = q == 2'd0 || q == 2'd3; sda_oe = bc != 4'd8 && !sh[7]; end
      S_RD:    begin scl_oe = q == 2'd0 || q == 2'd3; sda_oe = bc == 4'd8 && rd_ack; end
      S_HOLD:  scl_oe = 1'b1;
      S_STOP:  begin scl_oe = q == 2'd0; sda_oe = !q[1]; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (push_ok) txm[twp] <= tx_word;
    if (rx_in && !rx_full) rxm[rwp] <= sh;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      twp <= '0; trp <= '0; tcnt <= '0;
      rwp <= '0; rrp <= '0; rcnt <= '0;
    end else begin
      if (nack_abort) begin
        trp  <= twp;
        tcnt <= '0;
      end else begin
        if (push_ok) twp <= twp + AW'(1);
        if (tx_pop) trp <= trp + AW'(1);
        tcnt <= tcnt + CW'(push_ok) - CW'(tx_pop);
      end
      if (rx_in && !rx_full) rwp <= rwp + AW'(1);
      if (pop_ok) rrp <= rrp + AW'(1);
      rcnt <= rcnt + CW'(rx_in && !rx_full) - CW'(pop_ok);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      abort_src   <= '0;
      rx_overflow <= 1'b0;
      addr_q      <= '0;
    end else begin
      if (addr_load && tx_empty && !active) addr_q <= target_addr;
      if (err_clr) begin
        abort_src   <= '0;
        rx_overflow <= 1'b0;
      end
      if (nack_abort) abort_src[st == S_WR] <= 1'b1;
      if (rx_in && rx_full) rx_overflow <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; q <= '0; bc <= '0; sh <= '0;
      dir <= 1'b0; cur_stop <= 1'b0; need_rs <= 1'b0;
      nack_got <= 1'b0; rd_ack <= 1'b0;
    end else if (tick) begin
      q <= q + 2'd1;
      case (st)
        S_IDLE: begin
          q <= '0;
          if (enable && !tx_empty) begin
            st <= S_START; dir <= head[8]; sh <= {addr_q, head[8]};
            need_rs <= 1'b0; cur_stop <= 1'b0; bc <= '0;
          end
        end
        S_START: if (q == 2'd3) st <= S_ADDR;
        S_ADDR, S_WR: begin
          if (q == 2'd2 && bc == 4'd8) nack_got <= sda_in;
          if (q == 2'd3 && bc != 4'd8) begin
            sh <= {sh[6:0], 1'b0};
            bc <= bc + 4'd1;
          end
        end
        S_RD: begin
          if (q == 2'd2 && bc != 4'd8) sh <= {sh[6:0], sda_in};
          if (q == 2'd3 && bc != 4'd8) begin
            bc <= bc + 4'd1;
            if (bc == 4'd7) rd_ack <= !cur_stop && !tx_empty && head[8] && !head[9] && head[8] == dir;
          end
        end
        S_STOP: if (q == 2'd3) st <= S_IDLE;
        default: ;
      endcase
      if (nack_abort) begin
        st <= S_STOP; q <= '0;
      end else if (adv_now) begin
        st <= adv_st; q <= '0;
        if (adv_st == S_START) begin
          dir <= head[8]; sh <= {addr_q, head[8]};
          need_rs <= 1'b0; cur_stop <= 1'b0; bc <= '0;
        end else if (adv_pop) begin
          sh <= head[7:0]; cur_stop <= head[9]; bc <= '0; need_rs <= 1'b0;
        end else begin
          need_rs <= rs_req; cur_stop <= 1'b0;
        end
      end
    end
  end

endmodule

module i2c_cmd_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       enable,
  input logic [6:0] status,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic [1:0] abort_src,
  input logic       rx_overflow,
  input logic       err_clr
);
  a_r11_idle_release: assert property (@(posedge clk) disable iff (!rst_n)
    !status[5] |-> (!scl_oe && !sda_oe));
  a_r11_scl_paced: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(tick) |-> $stable(scl_oe));
  a_r7_rx_full_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    status[4] |-> status[3]);
  a_r7_tx_empty_nfull: assert property (@(posedge clk) disable iff (!rst_n)
    status[2] |-> status[1]);
  a_r8_abort_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_src != 2'b00 && !err_clr) |=> abort_src != 2'b00);
  a_r9_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_overflow && !err_clr) |=> rx_overflow);
  a_r12_no_start_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !status[5]) |=> !status[5]);
endmodule

bind i2c_cmd_master i2c_cmd_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .enable(enable), .status(status),
  .scl_oe(scl_oe), .sda_oe(sda_oe), .abort_src(abort_src),
  .rx_overflow(rx_overflow), .err_clr(err_clr)
);

// File: tb/test_i2c_cmd_master.sv
module test_i2c_cmd_master;
  localparam int DEPTH = 4;
  localparam logic [6:0] SL_ADDR = 7'h2A;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic enable = 1'b0, stop_hold = 1'b0, addr_load = 1'b0, tx_push = 1'b0, rx_pop = 1'b0, err_clr = 1'b0;
  logic [6:0] target_addr = '0;
  logic [9:0] tx_word = '0;
  logic [7:0] rx_byte;
  logic [6:0] status;
  logic [1:0] abort_src;
  logic rx_overflow, scl_oe, sda_oe;

  int nchk = 0, nfail = 0;

  logic sl_drive = 1'b0;
  wire scl = !scl_oe;
  wire sda = !(sda_oe || sl_drive);

  i2c_cmd_master #(.DEPTH(DEPTH)) i_i2c_cmd_master (
    .clk(clk), .rst_n(rst_n), .enable(enable), .stop_hold(stop_hold), .tick(tick),
    .addr_load(addr_load), .target_addr(target_addr), .tx_push(tx_push), .tx_word(tx_word),
    .rx_pop(rx_pop), .rx_byte(rx_byte), .status(status), .abort_src(abort_src),
    .rx_overflow(rx_overflow), .err_clr(err_clr), .sda_in(sda), .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  always #2 clk = ~clk;
  always @(posedge clk) tick <= rst_n ? !tick : 1'b0;

  // target model
  logic scl_d = 1'b1, sda_d = 1'b1, act = 1'b0, aph = 1'b0, rdm = 1'b0, matched = 1'b0, m_ack = 1'b0;
  logic [3:0] cnt = '0;
  logic [7:0] ssh = '0, rsh = '0;
  logic [7:0] wlog [256];
  logic [7:0] alog [64];
  int wcnt = 0, acnt = 0, n_start = 0, n_stop = 0, rd_idx = 0, nack_at = -1;

  function automatic logic [7:0] rd_pat(input int i);
    return 8'(8'hC3 + i * 37);
  endfunction

  always @(posedge clk) begin
    scl_d <= scl;
    sda_d <= sda;
    if (scl && scl_d && sda_d && !sda) begin
      n_start <= n_start + 1; act <= 1'b1; aph <= 1'b1; cnt <= '0; sl_drive <= 1'b0; rdm <= 1'b0;
    end else if (scl && scl_d && !sda_d && sda) begin
      n_stop <= n_stop + 1; act <= 1'b0; sl_drive <= 1'b0;
    end else if (act) begin
      if (scl && !scl_d) begin
        if (cnt < 4'd8) begin
          if (!(rdm && !aph)) ssh <= {ssh[6:0], sda};
          cnt <= cnt + 4'd1;
        end else begin
          if (rdm && !aph) m_ack <= !sda;
          cnt <= 4'd9;
        end
      end
      if (!scl && scl_d) begin
        if (cnt == 4'd8) begin
          if (aph) begin
            alog[acnt[5:0]] <= ssh; acnt <= acnt + 1;
            matched <= ssh[7:1] == SL_ADDR;
            sl_drive <= ssh[7:1] == SL_ADDR;
            rdm <= ssh[0];
          end else if (!rdm) begin
            wlog[wcnt[7:0]] <= ssh; wcnt <= wcnt + 1;
            sl_drive <= wcnt != nack_at;
          end else sl_drive <= 1'b0;
        end else if (cnt == 4'd9) begin
          cnt <= '0; aph <= 1'b0;
          if (!matched) begin act <= 1'b0; sl_drive <= 1'b0; end
          else if (rdm && (aph || m_ack)) begin
            rsh <= rd_pat(rd_idx); sl_drive <= !rd_pat(rd_idx)[7]; rd_idx <= rd_idx + 1;
          end else sl_drive <= 1'b0;
        end else if (rdm && !aph && cnt >= 4'd1 && cnt <= 4'd7) begin
          sl_drive <= !rsh[3'd7 - cnt[2:0]];
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int actv, input int expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, actv, expv);
    end
  endtask

  task automatic push(input logic [9:0] w);
    @(negedge clk);
    while (!status[1]) @(negedge clk);
    tx_push = 1'b1; tx_word = w;
    @(negedge clk);
    tx_push = 1'b0;
  endtask

  task automatic push_raw(input logic [9:0] w);
    @(negedge clk);
    tx_push = 1'b1; tx_word = w;
    @(negedge clk);
    tx_push = 1'b0;
  endtask

  task automatic pop(output logic [7:0] v);
    @(negedge clk);
    v = rx_byte; rx_pop = 1'b1;
    @(negedge clk);
    rx_pop = 1'b0;
  endtask

  task automatic load_addr(input logic [6:0] a);
    @(negedge clk);
    target_addr = a; addr_load = 1'b1;
    @(negedge clk);
    addr_load = 1'b0;
  endtask

  task automatic wait_idle;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (!status[5] && status[2]) break;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic clear_err;
    @(negedge clk); err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;
  endtask

  task automatic finish_run;
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    int b0, s0, p0, a0, r0;
    logic [7:0] v;
    logic [7:0] wb [8];
    void'($urandom(32'd1789));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(status == 7'b0000110, "R7 reset status", status, 7'b0000110);
    chk(!scl_oe && !sda_oe, "R11 idle lines released", {scl_oe, sda_oe}, 0);
    chk(abort_src == 2'b00 && !rx_overflow, "R8 reset abort", abort_src, 0);
    load_addr(SL_ADDR);

    // R12 / R10: queue with enable low, overfill
    push_raw(10'h011); push_raw(10'h022); push_raw(10'h033); push_raw(10'h044);
    repeat (100) @(negedge clk);
    chk(n_start == 0 && !status[5], "R12 no start while disabled", n_start, 0);
    chk(status[1] == 1'b0, "R10 tx full", status, 0);
    push_raw(10'h055);
    enable = 1'b1;
    wait_idle();
    chk(wcnt == 4, "R10 push into full dropped", wcnt, 4);
    chk(wlog[0] == 8'h11 && wlog[1] == 8'h22 && wlog[2] == 8'h33 && wlog[3] == 8'h44,
        "R1 write bytes", {wlog[0], wlog[1], wlog[2], wlog[3]}, 32'h11223344);
    chk(alog[0] == 8'h54, "R1 write address byte", alog[0], 8'h54);
    chk(n_start == 1 && n_stop == 1, "R4 stop on empty without hold", n_stop, 1);

    // R2 reads, ignored byte field
    b0 = wcnt; r0 = rd_idx; a0 = acnt;
    push(10'h1FF); push(10'h1A5); push(10'h100);
    wait_idle();
    chk(wcnt == b0, "R1 read word byte ignored", wcnt, b0);
    chk(alog[a0[5:0]] == 8'h55, "R1 read address byte", alog[a0[5:0]], 8'h55);
    chk(rd_idx == r0 + 3, "R2 last byte NACKed", rd_idx - r0, 3);
    for (int k = 0; k < 3; k++) begin
      pop(v);
      chk(v == rd_pat(r0 + k), "R2 read data", v, rd_pat(r0 + k));
    end
    chk(!status[3], "R2 rx drained", status, 0);
    pop(v);
    chk(status == 7'b0000110, "R10 pop from empty ignored", status, 7'b0000110);

    // R5 write then read with repeated start
    s0 = n_start; p0 = n_stop; a0 = acnt; r0 = rd_idx; b0 = wcnt;
    push(10'h0A7); push(10'h100); push(10'h100);
    wait_idle();
    chk(n_start == s0 + 2 && n_stop == p0 + 1, "R5 repeated start", n_start - s0, 2);
    chk(alog[a0[5:0]] == 8'h54 && alog[6'(a0 + 1)] == 8'h55, "R5 direction in address",
        {alog[a0[5:0]], alog[6'(a0 + 1)]}, 16'h5455);
    chk(wlog[b0[7:0]] == 8'hA7, "R5 write before restart", wlog[b0[7:0]], 8'hA7);
    pop(v); chk(v == rd_pat(r0), "R5 read after restart", v, rd_pat(r0));
    pop(v); chk(v == rd_pat(r0 + 1), "R5 read after restart", v, rd_pat(r0 + 1));

    // R3 per-word stop
    s0 = n_start; p0 = n_stop;
    push(10'h233); push(10'h044);
    wait_idle();
    chk(n_start == s0 + 2 && n_stop == p0 + 2, "R3 stop bit splits transfer", n_stop - p0, 2);

    // R4 stop hold, R6 address load ignored while busy
    s0 = n_start; p0 = n_stop; b0 = wcnt;
    stop_hold = 1'b1;
    push(10'h066);
    while (wcnt < b0 + 1) @(negedge clk);
    repeat (60) @(negedge clk);
    chk(status[5] && scl_oe, "R4 bus held", {status[5], scl_oe}, 3);
    chk(n_stop == p0, "R4 no stop while held", n_stop - p0, 0);
    load_addr(7'h10);
    push(10'h077);
    while (wcnt < b0 + 2) @(negedge clk);
    repeat (60) @(negedge clk);
    chk(n_start == s0 + 1, "R4 resumes without start", n_start - s0, 1);
    stop_hold = 1'b0;
    wait_idle();
    chk(n_stop == p0 + 1 && !status[5], "R4 stop after hold cleared", n_stop - p0, 1);
    a0 = acnt;
    push(10'h088);
    wait_idle();
    chk(alog[a0[5:0]] == 8'h54, "R6 load while busy ignored", alog[a0[5:0]], 8'h54);

    // R8 address NACK
    load_addr(7'h11);
    b0 = wcnt; p0 = n_stop;
    push(10'h099); push(10'h0AA);
    wait_idle();
    chk(abort_src == 2'b01, "R8 address nack cause", abort_src, 1);
    chk(wcnt == b0 && n_stop == p0 + 1, "R8 flush and stop", wcnt - b0, 0);
    chk(status == 7'b0000110, "R8 back to idle", status, 7'b0000110);
    clear_err();
    chk(abort_src == 2'b00, "R9 err_clr clears abort", abort_src, 0);
    load_addr(SL_ADDR);

    // R8 data NACK
    b0 = wcnt; nack_at = wcnt + 1;
    push(10'h0B1); push(10'h0B2); push(10'h0B3);
    wait_idle();
    chk(abort_src == 2'b10, "R8 data nack cause", abort_src, 2);
    chk(wcnt == b0 + 2 && status[2], "R8 remaining word flushed", wcnt - b0, 2);
    nack_at = -1;
    clear_err();

    // R9 overflow
    r0 = rd_idx;
    for (int k = 0; k < 5; k++) push(10'h100);
    wait_idle();
    chk(rx_overflow && status[4], "R9 overflow flagged", {rx_overflow, status[4]}, 3);
    for (int k = 0; k < 4; k++) begin
      pop(v); chk(v == rd_pat(r0 + k), "R9 kept bytes", v, rd_pat(r0 + k));
    end
    chk(!status[3], "R9 fifth byte dropped", status, 0);
    clear_err();
    chk(!rx_overflow, "R9 overflow cleared", rx_overflow, 0);

    // random traffic
    for (int r = 0; r < 16; r++) begin
      int n;
      n = 1 + int'($urandom_range(5));
      if (r % 2 == 0) begin
        b0 = wcnt;
        for (int k = 0; k < n; k++) begin wb[k] = 8'($urandom); push({2'b00, wb[k]}); end
        wait_idle();
        for (int k = 0; k < n; k++)
          chk(wlog[8'(b0 + k)] == wb[k], "R1 random write", wlog[8'(b0 + k)], wb[k]);
      end else begin
        if (n > DEPTH) n = DEPTH;
        r0 = rd_idx;
        for (int k = 0; k < n; k++) push({2'b01, 8'($urandom)});
        wait_idle();
        for (int k = 0; k < n; k++) begin
          pop(v); chk(v == rd_pat(r0 + k), "R2 random read", v, rd_pat(r0 + k));
        end
      end
    end
    finish_run();
  end
endmodule